// File: doc/BRIEF.md
# Boot PROM Read Cycle Controller

This block answers host memory reads that an external address decoder has flagged as falling inside the boot PROM window. The PROM is a byte-wide device on a private bus, while the host side is a 16-bit system data bus with a ready line that can insert wait states. When a read strobe and the window-match input are both active, the controller pulls ready low at once. It then fetches one or two bytes, each through a chip-select pulse of fixed length. It assembles the result and drives it onto the system data lanes until the host drops the strobe.

A configuration bit chooses between 16-bit and 8-bit host cycles. A second input reports whether the byte-high enable line of the host is wired at all. When it is absent, every access uses the 8-bit form. In 16-bit form the word is built from the even and odd byte of the addressed pair. In 8-bit form a single byte is read from the exact address and only the low lane is driven. The PROM output enable is assumed tied active, so the chip select alone times each byte.

Top module: `bprom_read_ctrl`

## Requirements
- R1: A fetch starts only when `mem_rd` and `prom_hit` are both high. `rdy` drops to 0 combinationally in that same cycle. Either input alone leaves `rdy` at 1 and `prom_cs` at 0.
- R2: Each byte fetch raises `prom_cs` for exactly 3 consecutive clock cycles, and `prom_addr` holds steady throughout. Two fetches of one access are separated by at least one cycle with `prom_cs` low.
- R3: With `wide_cfg`=1 and `hi_en_present`=1, two fetches occur. The first uses the host address with bit 0 forced to 0 and lands on `sd_out[7:0]`. The second uses bit 0 forced to 1 and lands on `sd_out[15:8]`. Both `sd_oe_lo` and `sd_oe_hi` are 1 during the data phase.
- R4: With `wide_cfg`=0, one fetch occurs at the exact host address. Its byte appears on `sd_out[7:0]`, `sd_oe_hi` stays 0 and `sd_out[15:8]` reads 0.
- R5: With `hi_en_present`=0, the access behaves as in R4 whatever the value of `wide_cfg`.
- R6: `rdy` stays 0 from detection until the last byte is captured. It is 1 from then on for as long as the data is driven, and it is never 0 while an output enable is 1. A 16-bit access keeps `rdy` low for 8 cycles and an 8-bit access for 4 cycles, counting the detection cycle.
- R7: Output enables follow `mem_rd` during the data phase. They fall in the same cycle that `mem_rd` goes low, which ends the access.
- R8: A strobe held high after an access completes starts no further fetch. A new access needs `mem_rd` to have been sampled low at least once.
- R9: After reset `rdy`=1, `prom_cs`=0, and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (three periods form one chip-select pulse) |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host address offset within the PROM window |
| mem_rd | input | 1 | Host memory read strobe, active high |
| prom_hit | input | 1 | External decode: address falls in the PROM window |
| hi_en_present | input | 1 | 1 when the host byte-high enable is wired |
| wide_cfg | input | 1 | 1 selects 16-bit host cycles |
| prom_data | input | 8 | Byte returned by the PROM |
| prom_addr | output | 16 | Private-bus byte address |
| prom_cs | output | 1 | PROM chip select, active high |
| rdy | output | 1 | Host ready; 0 inserts wait states |
| sd_out | output | 16 | Data for the system data bus |
| sd_oe_lo | output | 1 | Drive enable for bits 7:0 |
| sd_oe_hi | output | 1 | Drive enable for bits 15:8 |

## Verification
A sequencer stuck in a fetch state shows at once as `rdy` staying low past the 8- or 4-cycle window. A wrong beat counter shows as a missing or extra chip-select run, or as swapped bytes on the lanes, by the time `rdy` rises. A pulse timer that is off by one shows on the first fetch as a chip-select run of the wrong length. A lost re-arm flag shows either as a second fetch during a held strobe or as a following access that never starts.

// File: rtl/bprom_pkg.sv
package bprom_pkg;

    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int CS_CYCLES = 3;
    localparam int BEATS     = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wide;
    } access_t;

    // Byte address of one beat: wide accesses replace bit 0 by the beat index.
    function automatic logic [ADDR_W-1:0] beat_addr(
        input logic [ADDR_W-1:0] base,
        input logic              wide,
        input logic              beat
    );
        return wide ? {base[ADDR_W-1:1], beat} : base;
    endfunction

endpackage

// File: rtl/bprom_arm.sv
module bprom_arm (
    input  logic clk,
    input  logic rst,
    input  logic mem_rd,
    input  logic take,
    output logic armed
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst)          armed_q <= 1'b0;
        else if (!mem_rd) armed_q <= 1'b1;
        else if (take)    armed_q <= 1'b0;
    end

    assign armed = armed_q;
endmodule

// File: rtl/bprom_pulse_timer.sv
module bprom_pulse_timer #(
    parameter int CS_CYCLES = bprom_pkg::CS_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CNT_W = $clog2(CS_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == CNT_W'(CS_CYCLES - 1));
endmodule

// File: rtl/bprom_assembler.sv
module bprom_assembler #(
    parameter int BYTE_W = bprom_pkg::BYTE_W,
    parameter int BEATS  = bprom_pkg::BEATS,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    capture,
    input  logic [BEAT_W-1:0]       beat,
    input  logic [BYTE_W-1:0]       byte_in,
    output logic [BEATS*BYTE_W-1:0] word
);
    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst || clear)
                lane_q <= '0;
            else if (capture && beat == BEAT_W'(g))
                lane_q <= byte_in;
        end
        assign word[g*BYTE_W +: BYTE_W] = lane_q;
    end
endmodule

// File: rtl/bprom_read_ctrl.sv
module bprom_read_ctrl
    import bprom_pkg::*;
#(
    parameter int CS_LEN = CS_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              mem_rd,
    input  logic              prom_hit,
    input  logic              hi_en_present,
    input  logic              wide_cfg,
    input  logic [BYTE_W-1:0] prom_data,
    output logic [ADDR_W-1:0] prom_addr,
    output logic              prom_cs,
    output logic              rdy,
    output logic [2*BYTE_W-1:0] sd_out,
    output logic              sd_oe_lo,
    output logic              sd_oe_hi
);
    localparam int RUN_W = $clog2(CS_LEN + 2);

    seq_state_t state_q, state_d;
    access_t    acc_q;
    logic       beat_q;
    logic       armed, start, beat_last;
    logic [2*BYTE_W-1:0] word;

    bprom_arm u_arm (
        .clk    (clk),
        .rst    (rst),
        .mem_rd (mem_rd),
        .take   (start),
        .armed  (armed)
    );

    bprom_pulse_timer #(.CS_CYCLES(CS_LEN)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_STROBE),
        .last (beat_last)
    );

    bprom_assembler #(.BYTE_W(BYTE_W), .BEATS(2)) u_asm (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .capture (beat_last),
        .beat    (beat_q),
        .byte_in (prom_data),
        .word    (word)
    );

    assign start = (state_q == ST_IDLE) && mem_rd && prom_hit && armed;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_STROBE;
            ST_STROBE: if (beat_last)
                           state_d = (acc_q.wide && !beat_q) ? ST_GAP : ST_HOLD;
            ST_GAP:    state_d = ST_STROBE;
            ST_HOLD:   if (!mem_rd) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            beat_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                acc_q.addr <= host_addr;
                acc_q.wide <= wide_cfg && hi_en_present;
                beat_q     <= 1'b0;
            end else if (state_q == ST_GAP) begin
                beat_q <= 1'b1;
            end
        end
    end

    assign prom_addr = beat_addr(acc_q.addr, acc_q.wide, beat_q);
    assign prom_cs   = (state_q == ST_STROBE);
    assign rdy       = !(start || state_q == ST_STROBE || state_q == ST_GAP);
    assign sd_oe_lo  = (state_q == ST_HOLD) && mem_rd;
    assign sd_oe_hi  = sd_oe_lo && acc_q.wide;
    assign sd_out    = {acc_q.wide ? word[2*BYTE_W-1:BYTE_W] : {BYTE_W{1'b0}},
                        word[BYTE_W-1:0]};

    // Observation of chip-select run length for the pulse-width check.
    logic [RUN_W-1:0] cs_run_q;
    always_ff @(posedge clk) begin
        if (rst || !prom_cs) cs_run_q <= '0;
        else if (cs_run_q != {RUN_W{1'b1}}) cs_run_q <= cs_run_q + 1'b1;
    end

    // R2
    cs_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(prom_cs) |-> cs_run_q == RUN_W'(CS_LEN));

    // R2
    cs_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (prom_cs && $past(prom_cs)) |-> $stable(prom_addr));

    // R6
    fetch_stall_chk: assert property (@(posedge clk) disable iff (rst)
        prom_cs |-> !rdy);

    // R6
    data_ready_chk: assert property (@(posedge clk) disable iff (rst)
        sd_oe_lo |-> rdy);

    // R3
    hi_lane_chk: assert property (@(posedge clk) disable iff (rst)
        sd_oe_hi |-> sd_oe_lo);

    // R7
    oe_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_rd |-> !sd_oe_lo);

    // R1
    no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (!prom_hit && rdy && !prom_cs) |=> !prom_cs);
endmodule

// File: tb/bprom_read_ctrl_tb.sv
module bprom_read_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] host_addr;
    logic        mem_rd, prom_hit, hi_en_present, wide_cfg;
    logic [7:0]  prom_data;
    logic [15:0] prom_addr;
    logic        prom_cs, rdy, sd_oe_lo, sd_oe_hi;
    logic [15:0] sd_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    assign prom_data = prom_cs ? rom_byte(prom_addr) : 8'h00;

    bprom_read_ctrl u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .mem_rd(mem_rd),
        .prom_hit(prom_hit), .hi_en_present(hi_en_present), .wide_cfg(wide_cfg),
        .prom_data(prom_data), .prom_addr(prom_addr), .prom_cs(prom_cs),
        .rdy(rdy), .sd_out(sd_out), .sd_oe_lo(sd_oe_lo), .sd_oe_hi(sd_oe_hi)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; mem_rd = 0; prom_hit = 0; hi_en_present = 1; wide_cfg = 1;
        host_addr = '0;
        repeat (3) @(negedge clk);
        check(rdy == 1'b1 && prom_cs == 1'b0, "R9 ready/cs", {rdy, prom_cs}, 2'b10);
        check(!sd_oe_lo && !sd_oe_hi, "R9 enables", {sd_oe_hi, sd_oe_lo}, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Either qualifier alone must not start a fetch.
    task automatic t_no_trigger();
        bit bad = 0;
        host_addr = 16'h0123;
        mem_rd = 1; prom_hit = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!rdy || prom_cs) bad = 1;
        end
        mem_rd = 0; @(negedge clk);
        prom_hit = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!rdy || prom_cs) bad = 1;
        end
        prom_hit = 0; @(negedge clk);
        check(!bad, "R1 single qualifier ignored", bad, 0);
    endtask

    task automatic t_read(input logic [15:0] a, input logic wcfg, input logic hien, input string tag);
        bit          wide = wcfg && hien;
        int          nbytes = wide ? 2 : 1;
        int          run = 0, nruns = 0, low_cnt = 0;
        bit          len_bad = 0, addr_bad = 0, hold_bad = 0;
        logic [15:0] run_addr [2];
        logic [15:0] exp_a0, exp_a1, exp_word;
        bit          done = 0;

        exp_a0   = wide ? {a[15:1], 1'b0} : a;
        exp_a1   = {a[15:1], 1'b1};
        exp_word = wide ? {rom_byte(exp_a1), rom_byte(exp_a0)} : {8'h00, rom_byte(a)};

        mem_rd = 0; prom_hit = 0;
        @(negedge clk);
        host_addr = a; wide_cfg = wcfg; hi_en_present = hien;
        mem_rd = 1; prom_hit = 1;
        #1;
        check(rdy == 1'b0, {tag, " R1 ready drops at detection"}, rdy, 0);

        for (int i = 0; i < 40 && !done; i++) begin
            @(negedge clk);
            if (prom_cs) begin
                if (run == 0 && nruns < 2) run_addr[nruns] = prom_addr;
                else if (nruns < 2 && prom_addr != run_addr[nruns]) addr_bad = 1;
                run++;
            end else if (run > 0) begin
                if (run != 3) len_bad = 1;
                nruns++;
                run = 0;
            end
            if (rdy) done = 1;
            else low_cnt++;
        end

        check(!len_bad && !addr_bad, {tag, " R2 pulse length/address"}, {len_bad, addr_bad}, 0);
        check(nruns == nbytes, {tag, " R3/R4/R5 fetch count"}, nruns, nbytes);
        check(low_cnt + 1 == 4 * nbytes, {tag, " R6 wait cycles"}, low_cnt + 1, 4 * nbytes);
        if (nruns >= 1)
            check(run_addr[0] == exp_a0, {tag, " R3/R4 first address"}, run_addr[0], exp_a0);
        if (wide && nruns == 2)
            check(run_addr[1] == exp_a1, {tag, " R3 second address"}, run_addr[1], exp_a1);
        check(sd_out == exp_word, {tag, " R3/R4 data"}, sd_out, exp_word);
        check(sd_oe_lo == 1'b1 && sd_oe_hi == wide, {tag, " R3/R4 enables"},
              {sd_oe_hi, sd_oe_lo}, {wide, 1'b1});

        // Strobe held: no refetch, ready stays high, data stays driven (R8, R6).
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!rdy || prom_cs || !sd_oe_lo || sd_out != exp_word) hold_bad = 1;
        end
        check(!hold_bad, {tag, " R8 held strobe no refetch"}, hold_bad, 0);

        mem_rd = 0;
        #1;
        check(!sd_oe_lo && !sd_oe_hi, {tag, " R7 release on strobe end"}, {sd_oe_hi, sd_oe_lo}, 0);
        prom_hit = 0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_no_trigger();
        t_read(16'h1234, 1'b1, 1'b1, "R3 even");
        t_read(16'hABCD, 1'b1, 1'b1, "R3 odd");
        t_read(16'h00F7, 1'b0, 1'b1, "R4 narrow");
        t_read(16'h7FFE, 1'b1, 1'b0, "R5 no high enable");
        t_read(16'hFFFF, 1'b1, 1'b1, "R3 top");
        t_read(16'h0000, 1'b0, 1'b0, "R4 bottom");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule